// File: doc/BRIEF.md
# Horizontal Polyphase Sample Filter

This block is the horizontal half of a separable image scaler. It receives the already rounded intermediate samples of one line from the vertical stage and pushes them into a window of `NTAPS` taps. Each output pixel is the weighted sum of the window. The weights come from the phase that the phase generator names for that one output. The phase generator also says how many new samples the window must take in before the output is formed. The input sample rate and the output sample rate are therefore set only by the sequence of requests.

The weights sit in an internal bank of `NSETS` sets, each holding `NPHASE` phases of `NTAPS` signed 16-bit words. One set is active. A new set is chosen only on a frame-start pulse, and software reloads the other sets through a write port while the active set keeps filtering. At the left edge of a line the first sample is replicated so that it stands in for the samples before it. Past the last sample of a line the last sample is replicated, and no further input is taken.

Top module: `hpoly_filter`

## Requirements
- R1: While and just after reset, `out_valid` and `in_ready` are low and `req_ready` is high. The active coefficient set is 0 and every stored coefficient is 0.
- R2: An output equals round_sat(sum over i of win[i]*c[i] / 2^14). Here win[0] is the oldest tap, win[NTAPS-1] the newest, and win[NTAPS/2] is the sample the output is centred on. c[i] is tap i of the selected phase in the active set, as a signed 16-bit word with 14 fraction bits (16384 = 1.0).
- R3: Each request picks its own phase with `req_phase`. Successive outputs may use different phases.
- R4: A request shifts the window by `req_adv` samples before its output is formed, so `req_adv` = 0 repeats the previous window. Input samples are taken one per cycle when `in_valid` and `in_ready` are both high.
- R5: A request with `req_first` = 1 starts a new line. The first sample taken fills every tap and counts as NTAPS/2+1 valid taps. Shifting continues, beyond `req_adv` if needed, until all NTAPS taps are valid. With NTAPS = 4 and `req_adv` = 0, the first output therefore uses s0, s0, s0, s1.
- R6: After a sample taken with `in_last` = 1, any further shift in that line copies the newest tap into the window. `in_ready` stays low until the next `req_first` request.
- R7: The sum is rounded to nearest with halves going up. The result is saturated to 0 below and to 2^DATA_W-1 above.
- R8: A coefficient write (`cw_en` with set, phase, tap and data) stores into any set except the active one. A write aimed at the active set is ignored.
- R9: The active set becomes `frame_set` on a cycle with `frame_start` high, and it changes at no other time.
- R10: `req_ready` is high only while no request is in progress, and a request is taken on `req_valid` && `req_ready`. `in_ready` and `req_ready` are never high together. Each request yields exactly one output, in request order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_start | input | 1 | Frame boundary pulse; loads the active set |
| frame_set | input | SET_W | Set to make active at frame start |
| cw_en | input | 1 | Coefficient write strobe |
| cw_set | input | SET_W | Set addressed by the write |
| cw_phase | input | PH_W | Phase addressed by the write |
| cw_tap | input | TAP_W | Tap addressed by the write |
| cw_data | input | COEF_W | Signed coefficient word, 14 fraction bits |
| req_valid | input | 1 | Output request from the phase generator |
| req_first | input | 1 | Request begins a new line |
| req_adv | input | ADV_W | Samples to shift in before this output |
| req_phase | input | PH_W | Phase for this output |
| req_ready | output | 1 | Ready for a request |
| in_valid | input | 1 | Input sample valid |
| in_data | input | DATA_W | Input sample, unsigned |
| in_last | input | 1 | Sample is the last of its line |
| in_ready | output | 1 | Block takes an input sample this cycle |
| out_valid | output | 1 | Output pixel valid |
| out_data | output | DATA_W | Output pixel |

## Verification
Unity centre kernels on a ramp line expose the tap alignment and the left-edge fill, since each output must equal one known input sample. Kernels that differ from phase to phase, with advance values of 0 to 3, show whether the window moved by the right amount and whether the right phase was picked for each output. A short line with large advances drives the window past the last sample, where replicated values and a silent `in_ready` separate correct edge handling from reading stale input. Halfway, negative and oversized weights hit the rounding and both saturation limits. Writes aimed at the active and at an inactive set, with and without a frame start, separate the write-protection rule from the set-switch rule.

// File: rtl/hpf_pkg.sv
package hpf_pkg;

    localparam int ACC_MAX_W = 40;

    typedef logic signed [ACC_MAX_W-1:0] acc_t;

    typedef enum logic [0:0] {
        SEQ_IDLE  = 1'b0,
        SEQ_SHIFT = 1'b1
    } seq_state_t;

    typedef struct packed {
        logic valid;
        acc_t sum;
    } mac_stage_t;

    // number of valid taps after the first sample of a line
    function automatic int edge_fill(input int ntaps);
        return ntaps / 2 + 1;
    endfunction

    // round half up, then clamp into [0, 2^dw-1]
    function automatic acc_t round_sat(input acc_t acc, input int frac, input int dw);
        acc_t half;
        acc_t lim;
        acc_t r;
        half = acc_t'(1) <<< (frac - 1);
        lim  = (acc_t'(1) <<< dw) - acc_t'(1);
        r    = (acc + half) >>> frac;
        if (r < 0)
            return '0;
        else if (r > lim)
            return lim;
        else
            return r;
    endfunction

endpackage

// File: rtl/hpf_coef_bank.sv
module hpf_coef_bank #(
    parameter int NTAPS  = 4,
    parameter int NPHASE = 4,
    parameter int NSETS  = 4,
    parameter int COEF_W = 16,
    localparam int SET_W = (NSETS  > 1) ? $clog2(NSETS)  : 1,
    localparam int PH_W  = (NPHASE > 1) ? $clog2(NPHASE) : 1,
    localparam int TAP_W = (NTAPS  > 1) ? $clog2(NTAPS)  : 1
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         frame_start,
    input  logic [SET_W-1:0]             frame_set,
    input  logic                         cw_en,
    input  logic [SET_W-1:0]             cw_set,
    input  logic [PH_W-1:0]              cw_phase,
    input  logic [TAP_W-1:0]             cw_tap,
    input  logic [COEF_W-1:0]            cw_data,
    input  logic [PH_W-1:0]              rd_phase,
    output logic [SET_W-1:0]             active_set,
    output logic [NTAPS-1:0][COEF_W-1:0] rd_coefs
);

    logic [COEF_W-1:0] mem [NSETS][NPHASE][NTAPS];

    always_ff @(posedge clk) begin
        if (rst) begin
            active_set <= '0;
            for (int s = 0; s < NSETS; s++)
                for (int p = 0; p < NPHASE; p++)
                    for (int t = 0; t < NTAPS; t++)
                        mem[s][p][t] <= '0;
        end else begin
            if (cw_en && (cw_set != active_set))
                mem[cw_set][cw_phase][cw_tap] <= cw_data;
            if (frame_start)
                active_set <= frame_set;
        end
    end

    always_comb begin
        for (int t = 0; t < NTAPS; t++)
            rd_coefs[t] = mem[active_set][rd_phase][t];
    end

endmodule

// File: rtl/hpf_window.sv
module hpf_window #(
    parameter int NTAPS  = 4,
    parameter int DATA_W = 8,
    localparam int CNT_W = $clog2(NTAPS + 1)
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         clear,
    input  logic                         shift,
    input  logic [DATA_W-1:0]            din,
    output logic [NTAPS-1:0][DATA_W-1:0] taps,
    output logic                         full
);
    import hpf_pkg::*;

    localparam logic [CNT_W-1:0] FILL_CNT = CNT_W'(edge_fill(NTAPS));
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(NTAPS);

    logic [CNT_W-1:0] count;

    always_ff @(posedge clk) begin
        if (rst) begin
            count <= '0;
            taps  <= '0;
        end else if (clear) begin
            count <= '0;
        end else if (shift) begin
            if (count == '0) begin
                for (int k = 0; k < NTAPS; k++)
                    taps[k] <= din;
                count <= FILL_CNT;
            end else begin
                for (int k = 0; k < NTAPS - 1; k++)
                    taps[k] <= taps[k+1];
                taps[NTAPS-1] <= din;
                if (count != FULL_CNT)
                    count <= count + 1'b1;
            end
        end
    end

    assign full = (count == FULL_CNT);

endmodule

// File: rtl/hpf_mac.sv
module hpf_mac #(
    parameter int NTAPS  = 4,
    parameter int DATA_W = 8,
    parameter int COEF_W = 16,
    parameter int FRAC_W = 14,
    localparam int PROD_W = DATA_W + COEF_W + 1,
    localparam int ACC_W  = PROD_W + $clog2(NTAPS)
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         fire,
    input  logic [NTAPS-1:0][DATA_W-1:0] taps,
    input  logic [NTAPS-1:0][COEF_W-1:0] coefs,
    output logic                         out_valid,
    output logic [DATA_W-1:0]            out_data
);
    import hpf_pkg::*;

    logic signed [PROD_W-1:0] prod [NTAPS];
    acc_t                     sum;
    mac_stage_t               s1;

    for (genvar i = 0; i < NTAPS; i++) begin : g_prod
        assign prod[i] = $signed({{COEF_W{1'b0}}, 1'b0, taps[i]})
                       * $signed({{(DATA_W+1){coefs[i][COEF_W-1]}}, coefs[i]});
    end

    always_comb begin
        sum = '0;
        for (int i = 0; i < NTAPS; i++)
            sum = sum + acc_t'(prod[i]);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s1        <= '0;
            out_valid <= 1'b0;
            out_data  <= '0;
        end else begin
            s1.valid  <= fire;
            if (fire)
                s1.sum <= sum;
            out_valid <= s1.valid;
            if (s1.valid)
                out_data <= DATA_W'(round_sat(s1.sum, FRAC_W, DATA_W));
        end
    end

    initial begin
        if (ACC_W > ACC_MAX_W)
            $error("accumulator exceeds package width");
    end

endmodule

// File: rtl/hpoly_filter.sv
module hpoly_filter #(
    parameter int NTAPS   = 4,
    parameter int NPHASE  = 4,
    parameter int NSETS   = 4,
    parameter int DATA_W  = 8,
    parameter int COEF_W  = 16,
    parameter int FRAC_W  = 14,
    parameter int ADV_MAX = 4,
    localparam int SET_W = (NSETS  > 1) ? $clog2(NSETS)  : 1,
    localparam int PH_W  = (NPHASE > 1) ? $clog2(NPHASE) : 1,
    localparam int TAP_W = (NTAPS  > 1) ? $clog2(NTAPS)  : 1,
    localparam int ADV_W = $clog2(ADV_MAX + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              frame_start,
    input  logic [SET_W-1:0]  frame_set,
    input  logic              cw_en,
    input  logic [SET_W-1:0]  cw_set,
    input  logic [PH_W-1:0]   cw_phase,
    input  logic [TAP_W-1:0]  cw_tap,
    input  logic [COEF_W-1:0] cw_data,
    input  logic              req_valid,
    input  logic              req_first,
    input  logic [ADV_W-1:0]  req_adv,
    input  logic [PH_W-1:0]   req_phase,
    output logic              req_ready,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    input  logic              in_last,
    output logic              in_ready,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_data
);
    import hpf_pkg::*;

    seq_state_t                   st;
    logic [ADV_W-1:0]             rem;
    logic [PH_W-1:0]              phase_q;
    logic                         pad_q;
    logic                         full;
    logic                         need;
    logic                         shift;
    logic                         fire;
    logic                         clear;
    logic [DATA_W-1:0]            win_din;
    logic [SET_W-1:0]             active_set;
    logic [NTAPS-1:0][DATA_W-1:0] taps;
    logic [NTAPS-1:0][COEF_W-1:0] coefs;

    assign need      = (rem != '0) || !full;
    assign req_ready = (st == SEQ_IDLE);
    assign in_ready  = (st == SEQ_SHIFT) && need && !pad_q;
    assign shift     = (st == SEQ_SHIFT) && need && (pad_q || in_valid);
    assign fire      = (st == SEQ_SHIFT) && !need;
    assign clear     = (st == SEQ_IDLE) && req_valid && req_first;
    assign win_din   = pad_q ? taps[NTAPS-1] : in_data;

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= SEQ_IDLE;
            rem     <= '0;
            phase_q <= '0;
            pad_q   <= 1'b0;
        end else begin
            case (st)
                SEQ_IDLE: begin
                    if (req_valid) begin
                        st      <= SEQ_SHIFT;
                        rem     <= req_adv;
                        phase_q <= req_phase;
                        if (req_first)
                            pad_q <= 1'b0;
                    end
                end
                default: begin
                    if (shift) begin
                        if (rem != '0)
                            rem <= rem - 1'b1;
                        if (!pad_q && in_last)
                            pad_q <= 1'b1;
                    end
                    if (fire)
                        st <= SEQ_IDLE;
                end
            endcase
        end
    end

    hpf_coef_bank #(
        .NTAPS (NTAPS),
        .NPHASE(NPHASE),
        .NSETS (NSETS),
        .COEF_W(COEF_W)
    ) u_bank (
        .clk        (clk),
        .rst        (rst),
        .frame_start(frame_start),
        .frame_set  (frame_set),
        .cw_en      (cw_en),
        .cw_set     (cw_set),
        .cw_phase   (cw_phase),
        .cw_tap     (cw_tap),
        .cw_data    (cw_data),
        .rd_phase   (phase_q),
        .active_set (active_set),
        .rd_coefs   (coefs)
    );

    hpf_window #(
        .NTAPS (NTAPS),
        .DATA_W(DATA_W)
    ) u_win (
        .clk  (clk),
        .rst  (rst),
        .clear(clear),
        .shift(shift),
        .din  (win_din),
        .taps (taps),
        .full (full)
    );

    hpf_mac #(
        .NTAPS (NTAPS),
        .DATA_W(DATA_W),
        .COEF_W(COEF_W),
        .FRAC_W(FRAC_W)
    ) u_mac (
        .clk      (clk),
        .rst      (rst),
        .fire     (fire),
        .taps     (taps),
        .coefs    (coefs),
        .out_valid(out_valid),
        .out_data (out_data)
    );

endmodule

// File: rtl/hpoly_filter_chk.sv
module hpoly_filter_chk #(
    parameter int SET_W = 2
) (
    input logic             clk,
    input logic             rst,
    input logic             req_valid,
    input logic             req_ready,
    input logic             in_ready,
    input logic             out_valid,
    input logic             frame_start,
    input logic             pad_q,
    input logic [SET_W-1:0] active_set
);

    // R1
    reset_idle_chk: assert property (@(posedge clk)
        rst |=> (!out_valid && !in_ready && req_ready));

    // R10
    ready_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(in_ready && req_ready));

    // R10
    req_busy_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> !req_ready);

    // R6
    pad_stall_chk: assert property (@(posedge clk) disable iff (rst)
        pad_q |-> !in_ready);

    // R9
    set_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !frame_start |=> $stable(active_set));

endmodule

bind hpoly_filter hpoly_filter_chk #(.SET_W(SET_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .in_ready   (in_ready),
    .out_valid  (out_valid),
    .frame_start(frame_start),
    .pad_q      (pad_q),
    .active_set (active_set)
);

// File: tb/hpoly_filter_test.sv
module hpoly_filter_test;

    localparam int N = 4;
    localparam int NPH = 4;
    localparam int NS = 4;
    localparam int DW = 8;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        frame_start = 1'b0;
    logic [1:0]  frame_set = '0;
    logic        cw_en = 1'b0;
    logic [1:0]  cw_set = '0;
    logic [1:0]  cw_phase = '0;
    logic [1:0]  cw_tap = '0;
    logic [15:0] cw_data = '0;
    logic        req_valid = 1'b0;
    logic        req_first = 1'b0;
    logic [2:0]  req_adv = '0;
    logic [1:0]  req_phase = '0;
    logic        req_ready;
    logic        in_valid = 1'b0;
    logic [7:0]  in_data = '0;
    logic        in_last = 1'b0;
    logic        in_ready;
    logic        out_valid;
    logic [7:0]  out_data;

    always #2.5 clk = ~clk;

    hpoly_filter #(
        .NTAPS(N), .NPHASE(NPH), .NSETS(NS), .DATA_W(DW),
        .COEF_W(16), .FRAC_W(14), .ADV_MAX(4)
    ) uut (.*);

    int nchk = 0;
    int nerr = 0;

    // bench model
    int    coefm [NS][NPH][N];
    int    aset = 0;
    int    line [32];
    int    llen = 0;
    int    wm [N];
    int    mcount = 0;
    int    mpad = 0;
    int    midx = 0;
    int    didx = 0;
    int    edge_err = 0;
    int    expq [256];
    string tagq [256];
    int    wr = 0;
    int    rd = 0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (!rst && out_valid) begin
            if (rd < wr)
                chk(int'(out_data) == expq[rd], tagq[rd], int'(out_data), expq[rd]);
            else
                chk(1'b0, "R10", int'(out_data), -1);
            rd++;
        end
    end

    function automatic int model_out(input int ph);
        longint acc = 0;
        longint r;
        for (int i = 0; i < N; i++)
            acc += longint'(wm[i]) * longint'(coefm[aset][ph][i]);
        r = (acc + 64'sd8192) >>> 14;
        if (r < 0) r = 0;
        if (r > 255) r = 255;
        return int'(r);
    endfunction

    task automatic model_shift();
        int v;
        if (mpad != 0) v = wm[N-1];
        else begin
            v = line[midx];
            if (midx == llen - 1) mpad = 1;
            midx++;
        end
        if (mcount == 0) begin
            for (int k = 0; k < N; k++) wm[k] = v;
            mcount = N / 2 + 1;
        end else begin
            for (int k = 0; k < N - 1; k++) wm[k] = wm[k+1];
            wm[N-1] = v;
            if (mcount < N) mcount++;
        end
    endtask

    task automatic write_coef(input int s, input int p, input int t, input int v);
        @(negedge clk);
        cw_en = 1'b1; cw_set = 2'(s); cw_phase = 2'(p); cw_tap = 2'(t); cw_data = 16'(v);
        @(negedge clk);
        cw_en = 1'b0;
        if (s != aset) coefm[s][p][t] = v;   // R8: active set is protected
    endtask

    task automatic load_kernel(input int s, input int p, input int c0, input int c1,
                               input int c2, input int c3);
        write_coef(s, p, 0, c0);
        write_coef(s, p, 1, c1);
        write_coef(s, p, 2, c2);
        write_coef(s, p, 3, c3);
    endtask

    task automatic new_frame(input int s);
        @(negedge clk);
        frame_start = 1'b1; frame_set = 2'(s);
        @(negedge clk);
        frame_start = 1'b0;
        aset = s;
    endtask

    task automatic set_line(input int len, input int base, input int step);
        llen = len;
        for (int k = 0; k < len; k++) line[k] = (base + k * step) % 256;
    endtask

    task automatic issue_req(input bit first, input int adv, input int ph, input string tag);
        bit drove = 0;
        int rem = adv;
        if (first) begin
            mcount = 0; mpad = 0; midx = 0; didx = 0;
        end
        while (rem > 0 || mcount < N) begin
            model_shift();
            if (rem > 0) rem--;
        end
        expq[wr] = model_out(ph);
        tagq[wr] = tag;
        wr++;
        @(negedge clk);
        req_valid = 1'b1; req_first = first; req_adv = 3'(adv); req_phase = 2'(ph);
        @(negedge clk);
        req_valid = 1'b0; req_first = 1'b0;
        forever begin
            if (in_ready) begin
                if (didx < llen) begin
                    in_valid = 1'b1;
                    in_data = 8'(line[didx]);
                    in_last = (didx == llen - 1);
                    drove = 1;
                end else edge_err++;
            end
            @(negedge clk);
            if (drove) didx++;
            drove = 0;
            in_valid = 1'b0; in_last = 1'b0;
            if (req_ready) break;
        end
    endtask

    task automatic drain();
        repeat (6) @(negedge clk);
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk(out_valid == 1'b0, "R1", int'(out_valid), 0);
        chk(in_ready == 1'b0, "R1", int'(in_ready), 0);
        chk(req_ready == 1'b1, "R1", int'(req_ready), 1);
    endtask

    task automatic t_unity();
        set_line(12, 10, 10);
        issue_req(1, 0, 0, "R5");
        issue_req(0, 1, 0, "R2");
        issue_req(0, 1, 0, "R2");
        issue_req(0, 0, 0, "R4");
        drain();
    endtask

    task automatic t_phases();
        set_line(16, 7, 13);
        issue_req(1, 0, 1, "R5");
        issue_req(0, 1, 2, "R3");
        issue_req(0, 0, 3, "R3");
        issue_req(0, 1, 0, "R3");
        issue_req(0, 1, 1, "R3");
        drain();
    endtask

    task automatic t_advance();
        set_line(20, 250, 37);
        issue_req(1, 2, 0, "R4");
        issue_req(0, 3, 1, "R4");
        issue_req(0, 0, 2, "R4");
        issue_req(0, 2, 3, "R4");
        issue_req(0, 1, 1, "R4");
        drain();
    endtask

    task automatic t_edge();
        set_line(5, 40, 30);
        edge_err = 0;
        issue_req(1, 0, 2, "R5");
        issue_req(0, 2, 2, "R6");
        issue_req(0, 3, 3, "R6");
        issue_req(0, 4, 2, "R6");
        issue_req(0, 2, 1, "R6");
        drain();
        chk(edge_err == 0, "R6", edge_err, 0);
    endtask

    task automatic t_round();
        load_kernel(2, 0, 0, 0, 8192, 0);      // half weight
        load_kernel(2, 1, 0, 0, -16384, 0);    // negative
        load_kernel(2, 2, 0, 0, 32767, 0);     // near 2.0
        load_kernel(2, 3, 16384, 16384, 16384, 16384);
        new_frame(2);
        line[0] = 3; line[1] = 201; line[2] = 77; line[3] = 9; line[4] = 120;
        line[5] = 255; line[6] = 1; line[7] = 60;
        llen = 8;
        issue_req(1, 0, 0, "R7");   // 1.5 -> 2
        issue_req(0, 1, 1, "R7");   // negative -> 0
        issue_req(0, 0, 2, "R7");   // 402 -> 255
        issue_req(0, 2, 3, "R7");   // sum of four -> clamp
        issue_req(0, 1, 0, "R7");
        drain();
    endtask

    task automatic t_bank();
        // active set is 2 here
        write_coef(2, 0, 2, 16384);            // R8: must be ignored
        load_kernel(3, 0, 0, 16384, 0, 0);
        load_kernel(3, 1, 4096, 4096, 4096, 4096);
        set_line(10, 33, 21);
        issue_req(1, 0, 0, "R8");
        issue_req(0, 1, 0, "R9");
        drain();
        new_frame(3);
        issue_req(0, 1, 0, "R9");
        issue_req(0, 1, 1, "R9");
        drain();
    endtask

    initial begin
        for (int s = 0; s < NS; s++)
            for (int p = 0; p < NPH; p++)
                for (int t = 0; t < N; t++) coefm[s][p][t] = 0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        t_reset();
        load_kernel(1, 0, 0, 0, 16384, 0);
        load_kernel(1, 1, 0, 0, 8192, 8192);
        load_kernel(1, 2, -1024, 9000, 9000, -600);
        load_kernel(1, 3, 2000, 4000, 6000, 4384);
        new_frame(1);
        t_unity();
        t_phases();
        t_advance();
        t_edge();
        t_round();
        t_bank();
        chk(rd == wr, "R10", rd, wr);
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        nchk++;
        nerr++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

endmodule